// File: doc/BRIEF.md
# Command Transaction Sequencer

This block runs one complete request/response exchange with a command-driven microcontroller over a byte link. A host loads up to sixteen argument bytes into the internal argument buffer, presents an opcode, an argument count and an expected response count, and pulses start. The sequencer pushes the opcode into the transmit FIFO, followed by the argument bytes. It then pops one acknowledge byte from the receive FIFO and throws it away. After that it pops the response bytes into the internal response buffer and pulses done.

Both FIFOs sit inside the block. The microcontroller drains the transmit FIFO with a valid/ready pair and fills the receive FIFO the same way. Before every byte it moves, the sequencer waits on the relevant FIFO flag. Each wait is bounded. When a wait expires, the exchange is cut short with a timeout flag. Two-byte status replies arrive most significant byte first, and the block presents them as a 16-bit word. Examples are opcode 0x0C, which reads the event status and resets it, and opcode 0x1B, which reads it without resetting it. Both take no arguments and return two bytes.

Top module: `cmd_seq`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o and mcu_tx_valid_o are all low.
- R2: The link carries the opcode first, then argument bytes 0, 1, ... n-1 from the argument buffer. No byte is pushed while the transmit FIFO is full, so a stalled consumer only delays the sequence and loses no byte.
- R3: The first byte taken from the receive FIFO after the request is the acknowledge. It is discarded and never written to the response buffer. Bytes are taken only while the receive FIFO holds data.
- R4: Response bytes are stored in arrival order at response buffer addresses 0 to m-1, and each can be read back on rsp_data_o through rsp_addr_i.
- R5: rsp_word_o always equals response byte 0 times 256 plus response byte 1.
- R6: An argument count of zero sends only the opcode. A response count of zero ends the exchange right after the acknowledge.
- R7: An argument or response count above 16 is treated as 16.
- R8: When any single byte waits POLL_LIMIT consecutive cycles without progress, timeout_o is set, done_o pulses and the block returns to idle. timeout_o stays high until the next accepted start.
- R9: busy_o rises in the cycle after an accepted start and stays high through the done_o cycle, then falls. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an exchange; accepted only when idle |
| opcode_i | input | 8 | Command opcode |
| arg_cnt_i | input | 5 | Number of argument bytes (clamped to 16) |
| rsp_cnt_i | input | 5 | Number of response bytes (clamped to 16) |
| arg_we_i | input | 1 | Argument buffer write enable |
| arg_addr_i | input | 4 | Argument buffer write address |
| arg_data_i | input | 8 | Argument buffer write data |
| rsp_addr_i | input | 4 | Response buffer read address |
| rsp_data_o | output | 8 | Response byte at rsp_addr_i |
| rsp_word_o | output | 16 | Response bytes 0 and 1 as an MSB-first word |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle pulse at end of exchange |
| timeout_o | output | 1 | Last exchange aborted on an expired wait |
| mcu_tx_valid_o | output | 1 | Transmit FIFO holds a byte |
| mcu_tx_data_o | output | 8 | Head byte of the transmit FIFO |
| mcu_tx_ready_i | input | 1 | Microcontroller takes the head byte |
| mcu_rx_valid_i | input | 1 | Microcontroller offers a byte |
| mcu_rx_data_i | input | 8 | Offered byte |
| mcu_rx_ready_o | output | 1 | Receive FIFO has room |

## Verification
The hardest situation to reach is a transmit stall deep inside the argument phase. The four-entry transmit FIFO has to fill while the sequencer still has arguments left, and then stay blocked for the whole poll window. The bench gets there by holding mcu_tx_ready_i low through an eight-argument exchange, and it reaches the receive-side stall by never answering a no-argument status read. Both runs then drain the link. The randomized exchanges throttle both handshakes and use counts up to 17, so clamping and FIFO-full back-pressure occur along the way.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ARG,
    ST_ACK,
    ST_RSP,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4   // power of two
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;
  logic              push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= push_data_i;
        wr_q        <= wr_q + AW'(1);
      end
      if (pop_ok) rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
  import cmd_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BUF_DEPTH  = 16,
  parameter int POLL_LIMIT = 10000,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1),
  localparam int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic [CNT_W-1:0]  arg_cnt_i,
  input  logic [CNT_W-1:0]  rsp_cnt_i,
  output logic [IDX_W-1:0]  arg_rd_addr_o,
  input  logic [DATA_W-1:0] arg_rd_data_i,
  input  logic              tx_full_i,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_empty_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_pop_o,
  output logic              rsp_we_o,
  output logic [IDX_W-1:0]  rsp_wr_addr_o,
  output logic [DATA_W-1:0] rsp_wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  seq_state_e        state_q;
  logic [DATA_W-1:0] opc_q;
  logic [CNT_W-1:0]  na_q, nr_q, idx_q;
  logic [PW-1:0]     poll_q;
  logic              tmo_q;
  logic              stall, expire;

  function automatic logic [CNT_W-1:0] clamp(input logic [CNT_W-1:0] c);
    return (c > CNT_W'(BUF_DEPTH)) ? CNT_W'(BUF_DEPTH) : c;
  endfunction

  always_comb begin
    tx_push_o = 1'b0;
    rx_pop_o  = 1'b0;
    rsp_we_o  = 1'b0;
    stall     = 1'b0;
    unique case (state_q)
      ST_OPC, ST_ARG: begin
        tx_push_o = !tx_full_i;
        stall     = tx_full_i;
      end
      ST_ACK: begin
        rx_pop_o = !rx_empty_i;
        stall    = rx_empty_i;
      end
      ST_RSP: begin
        rx_pop_o = !rx_empty_i;
        rsp_we_o = !rx_empty_i;
        stall    = rx_empty_i;
      end
      default: ;
    endcase
  end

  assign expire        = stall && (poll_q == PW'(POLL_LIMIT - 1));
  assign tx_data_o     = (state_q == ST_OPC) ? opc_q : arg_rd_data_i;
  assign arg_rd_addr_o = idx_q[IDX_W-1:0];
  assign rsp_wr_addr_o = idx_q[IDX_W-1:0];
  assign rsp_wr_data_o = rx_data_i;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign timeout_o     = tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      opc_q   <= '0;
      na_q    <= '0;
      nr_q    <= '0;
      idx_q   <= '0;
      poll_q  <= '0;
      tmo_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          opc_q   <= opcode_i;
          na_q    <= clamp(arg_cnt_i);
          nr_q    <= clamp(rsp_cnt_i);
          idx_q   <= '0;
          poll_q  <= '0;
          tmo_q   <= 1'b0;
          state_q <= ST_OPC;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: begin
          if (expire) begin
            tmo_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (stall) begin
            poll_q <= poll_q + PW'(1);
          end else begin
            poll_q <= '0;
            unique case (state_q)
              ST_OPC: begin
                idx_q   <= '0;
                state_q <= (na_q == '0) ? ST_ACK : ST_ARG;
              end
              ST_ARG: if (idx_q == na_q - CNT_W'(1)) begin
                idx_q   <= '0;
                state_q <= ST_ACK;
              end else idx_q <= idx_q + CNT_W'(1);
              ST_ACK: begin
                idx_q   <= '0;
                state_q <= (nr_q == '0) ? ST_DONE : ST_RSP;
              end
              ST_RSP: if (idx_q == nr_q - CNT_W'(1)) state_q <= ST_DONE;
                      else idx_q <= idx_q + CNT_W'(1);
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assert_done_ends_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_busy_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  assert_busy_from_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_timeout_at_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);
  assert_poll_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PW'(POLL_LIMIT));
  assert_rsp_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_we_o |-> (idx_q < nr_q));
  assert_ack_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK) |-> !rsp_we_o);
  assert_count_clamped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (na_q <= CNT_W'(BUF_DEPTH) && nr_q <= CNT_W'(BUF_DEPTH)));
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq #(
  parameter int DATA_W     = 8,
  parameter int LINK_DEPTH = 4,
  parameter int BUF_DEPTH  = 16,
  parameter int POLL_LIMIT = 10000
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [DATA_W-1:0]                opcode_i,
  input  logic [$clog2(BUF_DEPTH+1)-1:0]   arg_cnt_i,
  input  logic [$clog2(BUF_DEPTH+1)-1:0]   rsp_cnt_i,
  input  logic                             arg_we_i,
  input  logic [$clog2(BUF_DEPTH)-1:0]     arg_addr_i,
  input  logic [DATA_W-1:0]                arg_data_i,
  input  logic [$clog2(BUF_DEPTH)-1:0]     rsp_addr_i,
  output logic [DATA_W-1:0]                rsp_data_o,
  output logic [2*DATA_W-1:0]              rsp_word_o,
  output logic                             busy_o,
  output logic                             done_o,
  output logic                             timeout_o,
  output logic                             mcu_tx_valid_o,
  output logic [DATA_W-1:0]                mcu_tx_data_o,
  input  logic                             mcu_tx_ready_i,
  input  logic                             mcu_rx_valid_i,
  input  logic [DATA_W-1:0]                mcu_rx_data_i,
  output logic                             mcu_rx_ready_o
);
  localparam int IDX_W = $clog2(BUF_DEPTH);

  logic [DATA_W-1:0] arg_mem [BUF_DEPTH];
  logic [DATA_W-1:0] rsp_mem [BUF_DEPTH];
  logic [IDX_W-1:0]  arg_rd_addr, rsp_wr_addr;
  logic [DATA_W-1:0] tx_data, rx_head, rsp_wr_data;
  logic              tx_push, tx_full, tx_empty;
  logic              rx_pop, rx_full, rx_empty, rsp_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BUF_DEPTH; i++) begin
        arg_mem[i] <= '0;
        rsp_mem[i] <= '0;
      end
    end else begin
      if (arg_we_i) arg_mem[arg_addr_i] <= arg_data_i;
      if (rsp_we)   rsp_mem[rsp_wr_addr] <= rsp_wr_data;
    end
  end

  assign rsp_data_o     = rsp_mem[rsp_addr_i];
  assign rsp_word_o     = {rsp_mem[0], rsp_mem[1]};
  assign mcu_tx_valid_o = !tx_empty;
  assign mcu_rx_ready_o = !rx_full;

  byte_fifo #(.DATA_W(DATA_W), .DEPTH(LINK_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .push_data_i(tx_data),
    .pop_i(mcu_tx_ready_i && !tx_empty), .head_o(mcu_tx_data_o),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  byte_fifo #(.DATA_W(DATA_W), .DEPTH(LINK_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(mcu_rx_valid_i && !rx_full), .push_data_i(mcu_rx_data_i),
    .pop_i(rx_pop), .head_o(rx_head),
    .full_o(rx_full), .empty_o(rx_empty)
  );

  cmd_seq_ctrl #(.DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .POLL_LIMIT(POLL_LIMIT)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i, .opcode_i, .arg_cnt_i, .rsp_cnt_i,
    .arg_rd_addr_o(arg_rd_addr), .arg_rd_data_i(arg_mem[arg_rd_addr]),
    .tx_full_i(tx_full), .tx_push_o(tx_push), .tx_data_o(tx_data),
    .rx_empty_i(rx_empty), .rx_data_i(rx_head), .rx_pop_o(rx_pop),
    .rsp_we_o(rsp_we), .rsp_wr_addr_o(rsp_wr_addr), .rsp_wr_data_o(rsp_wr_data),
    .busy_o, .done_o, .timeout_o
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !mcu_tx_valid_o && !timeout_o));
endmodule

// File: tb/cmd_seq_bench.sv
module cmd_seq_bench;
  localparam int POLL = 10000;
  localparam logic [7:0] ACK = 8'hFA;

  logic       clk = 0, rst_n = 0;
  logic       start = 0, arg_we = 0, tx_ready = 0, rx_valid = 0;
  logic [7:0] opcode = 0, arg_data = 0, rx_data = 0;
  logic [4:0] arg_cnt = 0, rsp_cnt = 0;
  logic [3:0] arg_addr = 0, rsp_addr = 0;
  logic [7:0] rsp_data, tx_data;
  logic [15:0] rsp_word;
  logic       busy, done, tmo, tx_valid, rx_ready;

  int checks = 0, fails = 0;
  logic [7:0] args [16];
  logic [7:0] rsp_exp [16];
  logic [7:0] got_tx [40];
  int tx_n, done_cyc;
  bit got_done, got_tmo;

  always #4 clk = ~clk;

  cmd_seq u_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .arg_cnt_i(arg_cnt), .rsp_cnt_i(rsp_cnt), .arg_we_i(arg_we),
    .arg_addr_i(arg_addr), .arg_data_i(arg_data), .rsp_addr_i(rsp_addr),
    .rsp_data_o(rsp_data), .rsp_word_o(rsp_word), .busy_o(busy),
    .done_o(done), .timeout_o(tmo), .mcu_tx_valid_o(tx_valid),
    .mcu_tx_data_o(tx_data), .mcu_tx_ready_i(tx_ready),
    .mcu_rx_valid_i(rx_valid), .mcu_rx_data_i(rx_data), .mcu_rx_ready_o(rx_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int c);
    return (c > 16) ? 16 : c;
  endfunction

  function automatic int word_of(input logic [7:0] b0, input logic [7:0] b1);
    return b0 * 256 + b1;
  endfunction

  task automatic load_args();
    for (int i = 0; i < 16; i++) begin
      args[i] = 8'($urandom);
      @(negedge clk);
      arg_we = 1; arg_addr = 4'(i); arg_data = args[i];
    end
    @(negedge clk);
    arg_we = 0;
  endtask

  // stall: never take tx bytes; silent: never answer; poke: start pulse while busy
  task automatic run_txn(input logic [7:0] op, input int na, input int nr,
                         input bit stall, input bit silent, input bit poke);
    int cyc = 0, rx_sent = 0;
    bit r;
    for (int i = 0; i < 16; i++) rsp_exp[i] = 8'($urandom);
    tx_n = 0; got_done = 0; got_tmo = 0; done_cyc = 0;
    @(negedge clk);
    opcode = op; arg_cnt = 5'(na); rsp_cnt = 5'(nr); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R9 busy after start", busy, 1);
    while (!got_done && cyc < 3 * POLL) begin
      @(negedge clk);
      cyc++;
      if (done) begin
        got_done = 1; got_tmo = tmo; done_cyc = cyc;
      end
      r = stall ? 1'b0 : ($urandom % 4 != 0);
      if (r && tx_valid && tx_n < 40) begin
        got_tx[tx_n] = tx_data; tx_n++;
      end
      tx_ready = r;
      if (!silent && tx_n == 1 + eff(na) && rx_sent < 1 + eff(nr) && rx_ready
          && ($urandom % 3 != 0)) begin
        rx_valid = 1;
        rx_data = (rx_sent == 0) ? ACK : rsp_exp[rx_sent - 1];
        rx_sent++;
      end else rx_valid = 0;
      if (poke && cyc == 3) begin
        start = 1; opcode = ~op;
      end else start = 0;
    end
    tx_ready = 0; rx_valid = 0; start = 0;
    chk(got_done, "R9 done reached", got_done, 1);
    @(negedge clk);
    chk(busy == 0, "R9 busy drops after done", busy, 0);
  endtask

  task automatic check_normal(input logic [7:0] op, input int na, input int nr, input string tag);
    chk(got_tmo == 0, {tag, " R8 no timeout"}, got_tmo, 0);
    chk(tx_n == 1 + eff(na), {tag, " R2 tx count"}, tx_n, 1 + eff(na));
    chk(got_tx[0] == op, {tag, " R2 opcode first"}, got_tx[0], op);
    for (int i = 0; i < eff(na) && i + 1 < tx_n; i++)
      chk(got_tx[i + 1] == args[i], {tag, " R2 arg order"}, got_tx[i + 1], args[i]);
    for (int i = 0; i < eff(nr); i++) begin
      rsp_addr = 4'(i);
      #1;
      chk(rsp_data == rsp_exp[i], {tag, " R4 R3 rsp byte"}, rsp_data, rsp_exp[i]);
    end
    if (eff(nr) >= 2)
      chk(int'(rsp_word) == word_of(rsp_exp[0], rsp_exp[1]), {tag, " R5 word"},
          rsp_word, word_of(rsp_exp[0], rsp_exp[1]));
  endtask

  task automatic drain_tx(input int n);
    tx_n = 0;
    repeat (n) begin
      @(negedge clk);
      if (tx_valid) begin
        got_tx[tx_n] = tx_data; tx_n++;
      end
      tx_ready = 1;
    end
    @(negedge clk);
    tx_ready = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && tmo == 0 && tx_valid == 0, "R1 reset state",
        {busy, done, tmo, tx_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && tx_valid == 0, "R1 idle after reset", {busy, tx_valid}, 0);

    // event status read, no args, two bytes back
    load_args();
    run_txn(8'h0C, 0, 2, 0, 0, 0);
    check_normal(8'h0C, 0, 2, "R6 event");
    run_txn(8'h1B, 0, 2, 0, 0, 0);
    check_normal(8'h1B, 0, 2, "R6 event_keep");
    // args, zero response
    run_txn(8'h23, 3, 0, 0, 0, 0);
    check_normal(8'h23, 3, 0, "R6 no_rsp");
    // clamp both counts
    load_args();
    run_txn(8'h41, 20, 17, 0, 0, 0);
    check_normal(8'h41, 20, 17, "R7 clamp");
    // start while busy ignored
    run_txn(8'h10, 5, 4, 0, 0, 1);
    check_normal(8'h10, 5, 4, "R9 poke");
    repeat (3) @(negedge clk);
    chk(busy == 0, "R9 no restart from ignored start", busy, 0);

    // transmit stall in argument phase
    load_args();
    run_txn(8'h50, 8, 2, 1, 1, 0);
    chk(got_tmo == 1, "R8 tx timeout flag", got_tmo, 1);
    chk(done_cyc >= POLL, "R8 waited full window", done_cyc, POLL);
    chk(tx_n == 0, "R8 nothing taken", tx_n, 0);
    repeat (3) @(negedge clk);
    chk(tmo == 1, "R8 flag held", tmo, 1);
    drain_tx(8);
    chk(tx_n == 4, "R2 fifo held four", tx_n, 4);
    chk(got_tx[0] == 8'h50 && got_tx[1] == args[0] && got_tx[3] == args[2],
        "R2 stalled bytes intact", got_tx[3], args[2]);

    // receive stall waiting for acknowledge
    run_txn(8'h11, 0, 2, 0, 1, 0);
    chk(got_tmo == 1, "R8 rx timeout flag", got_tmo, 1);
    chk(tx_n == 1 && got_tx[0] == 8'h11, "R2 opcode sent before ack wait", got_tx[0], 8'h11);

    // random exchanges
    for (int t = 0; t < 30; t++) begin
      int na, nr;
      logic [7:0] op;
      na = $urandom % 18; nr = $urandom % 18; op = 8'($urandom);
      if (t % 5 == 0) load_args();
      run_txn(op, na, nr, 0, 0, 0);
      check_normal(op, na, nr, "R2 R4 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule